// File: doc/BRIEF.md
# Counter Snapshot and Load Bridge

This block connects a processor bus, clocked by the bus clock, to a free-running counter that lives on a separate, unrelated slow clock. Software never touches the counter directly. It works through a 32-bit holding register that it can read and write one byte at a time. Two self-clearing command bits start the transfers:

- The **load command** moves the holding register into the counter.
- The **snapshot command** copies the current count back into the holding register.

The counter is never stopped. Each command crosses the clock boundary as a toggle request, and completes when a matching toggle acknowledge returns. The command bit reads 1 for the whole transfer. Software polls it and reads the holding register only after it returns to 0.

On the counter side the block gives a load value and a one-cycle load strobe to the counter logic, which is outside this block. It takes the live count as an input.

When both commands are pending together, the load is always carried out first, and the snapshot follows once the load has been acknowledged. While either command is pending, the holding register is frozen. This keeps the data that the slow domain samples stable, and it keeps a finished snapshot from being overwritten.

Top module: `snap_load_bridge`

## Requirements
- R1: After reset both command bits read 0, every byte of the holding register reads 0, and the load strobe is low.
- R2: A byte write with index k updates holding-register bits [8k+7:8k] only. A read with index k returns those same bits combinationally.
- R3: Each accepted load command produces exactly one load strobe, one counter-clock cycle wide. In that cycle the load value equals the holding register.
- R4: The load busy bit reads 1 from the bus cycle after the load command is written until the load has been acknowledged, and then returns to 0.
- R5: A completed snapshot holds one count value taken in a single counter cycle. That value is no smaller than the count when the command was written and no larger than the count when the busy bit cleared.
- R6: The snapshot busy bit reads 1 from the bus cycle after the snapshot command is written until the holding register holds the snapshot, and then returns to 0.
- R7: Byte writes made while either command bit is 1 are ignored. The holding register is left unchanged.
- R8: If load and snapshot are requested in the same cycle, the load runs first. The snapshot is then no smaller than the loaded value.
- R9: A command write made while that same command is still pending is ignored. It produces no second load strobe.
- R10: At most one request is in flight across the clock boundary at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus-domain clock |
| bus_rst_n | input | 1 | Bus-domain synchronous reset, active low |
| cnt_clk | input | 1 | Counter-domain clock |
| cnt_rst_n | input | 1 | Counter-domain synchronous reset, active low |
| bus_wr_en | input | 1 | Byte write strobe for the holding register |
| bus_wr_sel | input | 2 | Byte index of the write |
| bus_wr_data | input | 8 | Write data byte |
| bus_rd_sel | input | 2 | Byte index of the read |
| bus_rd_data | output | 8 | Selected byte of the holding register |
| cmd_load_wr | input | 1 | Writes 1 to the load command bit |
| cmd_snap_wr | input | 1 | Writes 1 to the snapshot command bit |
| load_busy | output | 1 | Load command bit, cleared by hardware |
| snap_busy | output | 1 | Snapshot command bit, cleared by hardware |
| live_count | input | 32 | Current counter value, counter domain |
| load_value | output | 32 | Value to be loaded into the counter |
| load_strobe | output | 1 | One-cycle load pulse, counter domain |

## Verification
The assertions rely on the two resets being held together for several cycles of both clocks, so that request and acknowledge toggles start out equal. They also assume that the counter-side request inputs change only through the synchronizer, which means a new request edge cannot arrive before the previous acknowledge. The stimulus drives every bus input half a bus period away from the active edge. It raises commands only through the two command strobes, and it waits for both busy bits to clear before it depends on the holding register. The snapshot checks then compare against a bounded window of the bench's own counter model rather than an exact value.

// File: rtl/snap_load_pkg.sv
// Package: shared types of the counter snapshot and load bridge.
// Assumes: one request/acknowledge toggle pair per command channel.
package snap_load_pkg;
    typedef struct packed {
        logic load;
        logic snap;
    } chan_t;

    localparam int CHAN_N = $bits(chan_t);
endpackage

// File: rtl/slb_sync.sv
// Multi-stage synchronizer for a vector of independent toggle signals.
// Assumes: each bit changes at most once per handshake, so bits need no
// mutual coherence; reset value is zero in the destination domain.
module slb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the toggle vector one stage deeper into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= d;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/slb_bus_ctl.sv
// Bus-side controller: holds the holding register, the two self-clearing
// command bits, and issues one toggle request at a time (load before snapshot).
// Assumes: ack_s is the acknowledge toggle already synchronized to clk, and
// snap_data is stable whenever the snapshot acknowledge has just returned.
module slb_bus_ctl
    import snap_load_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int BYTE_W = 8,
    localparam int NBYTES = CNT_W / BYTE_W,
    localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              cmd_load_wr,
    input  logic              cmd_snap_wr,
    input  chan_t             ack_s,
    input  logic [CNT_W-1:0]  snap_data,
    output logic [CNT_W-1:0]  hold_reg,
    output chan_t             req,
    output logic              load_busy,
    output logic              snap_busy
);
    logic             load_pend, snap_pend;
    logic             load_fly, snap_fly;
    logic             load_done, snap_done;
    logic             launch_load, launch_snap;
    logic             any_pend;
    logic [CNT_W-1:0] byte_mask;
    logic [CNT_W-1:0] wr_rep;

    // Completion: an in-flight request whose acknowledge has caught up.
    always_comb begin
        load_done = load_fly && (req.load == ack_s.load);
        snap_done = snap_fly && (req.snap == ack_s.snap);
        any_pend  = load_pend || snap_pend;
    end

    // Launch rules: one request in flight, a pending load goes before a snapshot.
    always_comb begin
        launch_load = load_pend && !load_fly && !snap_fly;
        launch_snap = snap_pend && !snap_fly && !load_pend && !load_fly;
    end

    genvar b;
    generate
        for (b = 0; b < NBYTES; b++) begin : g_byte
            // Decode the byte lane selected by the write index.
            assign byte_mask[b*BYTE_W +: BYTE_W] =
                (wr_en && (wr_sel == SEL_W'(b))) ? {BYTE_W{1'b1}} : '0;
            assign wr_rep[b*BYTE_W +: BYTE_W] = wr_data;
        end
    endgenerate

    // Holding register: byte writes while idle, snapshot copy on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_reg <= '0;
        else if (snap_done)
            hold_reg <= snap_data;
        else if (!any_pend)
            hold_reg <= (hold_reg & ~byte_mask) | (wr_rep & byte_mask);
    end

    // Command bits: set by a write, cleared by the returning acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_pend <= 1'b0;
            snap_pend <= 1'b0;
        end else begin
            if (load_done)        load_pend <= 1'b0;
            else if (cmd_load_wr) load_pend <= 1'b1;
            if (snap_done)        snap_pend <= 1'b0;
            else if (cmd_snap_wr) snap_pend <= 1'b1;
        end
    end

    // Request toggles and in-flight flags for both channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req      <= '0;
            load_fly <= 1'b0;
            snap_fly <= 1'b0;
        end else begin
            if (launch_load) begin
                req.load <= ~req.load;
                load_fly <= 1'b1;
            end else if (load_done) begin
                load_fly <= 1'b0;
            end
            if (launch_snap) begin
                req.snap <= ~req.snap;
                snap_fly <= 1'b1;
            end else if (snap_done) begin
                snap_fly <= 1'b0;
            end
        end
    end

    assign rd_data   = hold_reg[rd_sel*BYTE_W +: BYTE_W];
    assign load_busy = load_pend;
    assign snap_busy = snap_pend;

    // R7: holding register frozen while a command is pending and no snapshot lands.
    a_r7_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (any_pend && !snap_done) |=> $stable(hold_reg))
        else $error("a_r7_hold_frozen");

    // R10: never two requests in flight.
    a_r10_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_fly && snap_fly))
        else $error("a_r10_one_in_flight");

    // R4: the load bit cannot clear unless the acknowledge has just moved.
    a_r4_load_waits_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (load_busy && $stable(ack_s.load)) |=> load_busy)
        else $error("a_r4_load_waits_ack");

    // R6: the snapshot bit cannot clear unless the acknowledge has just moved.
    a_r6_snap_waits_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_busy && $stable(ack_s.snap)) |=> snap_busy)
        else $error("a_r6_snap_waits_ack");

    // R8: a snapshot request never leaves while a load is still pending.
    a_r8_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(req.snap) |-> !$past(load_pend))
        else $error("a_r8_load_first");
endmodule

// File: rtl/slb_cnt_side.sv
// Counter-side responder: detects request toggles, issues the load strobe
// with the holding value, takes a one-cycle snapshot, and returns acknowledges.
// Assumes: req_s is synchronized to clk; hold_data is frozen from request
// until acknowledge, so it can be sampled without further synchronization.
module slb_cnt_side
    import snap_load_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  chan_t            req_s,
    input  logic [CNT_W-1:0] hold_data,
    input  logic [CNT_W-1:0] live_count,
    output logic [CNT_W-1:0] load_value,
    output logic             load_strobe,
    output logic [CNT_W-1:0] snap,
    output chan_t            ack
);
    chan_t req_q;
    chan_t req_edge;

    // Edge of each synchronized request toggle.
    assign req_edge = req_s ^ req_q;

    // Remember the last seen request toggles.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_s;
    end

    // Load channel: drive value and strobe, then acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_value  <= '0;
            load_strobe <= 1'b0;
            ack.load    <= 1'b0;
        end else begin
            load_strobe <= req_edge.load;
            if (req_edge.load) begin
                load_value <= hold_data;
                ack.load   <= ~ack.load;
            end
        end
    end

    // Snapshot channel: capture all bits of the count at once, then acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap     <= '0;
            ack.snap <= 1'b0;
        end else if (req_edge.snap) begin
            snap     <= live_count;
            ack.snap <= ~ack.snap;
        end
    end

    // R3: the load strobe is a single-cycle pulse.
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |=> !load_strobe)
        else $error("a_r3_strobe_single");

    // R3: the load value changes only together with a strobe.
    a_r3_value_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !load_strobe |-> $stable(load_value))
        else $error("a_r3_value_with_strobe");

    // R5: the snapshot stays fixed while its acknowledge is unchanged.
    a_r5_snap_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(ack.snap) |-> $stable(snap))
        else $error("a_r5_snap_with_ack");
endmodule

// File: rtl/snap_load_bridge.sv
// Top: bridges byte-wide bus access and two self-clearing commands to a
// running counter on an asynchronous clock via toggle request/acknowledge.
// Assumes: both resets are asserted together for several cycles of each clock.
module snap_load_bridge
    import snap_load_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int NBYTES = CNT_W / BYTE_W,
    localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              cnt_clk,
    input  logic              cnt_rst_n,
    input  logic              bus_wr_en,
    input  logic [SEL_W-1:0]  bus_wr_sel,
    input  logic [BYTE_W-1:0] bus_wr_data,
    input  logic [SEL_W-1:0]  bus_rd_sel,
    output logic [BYTE_W-1:0] bus_rd_data,
    input  logic              cmd_load_wr,
    input  logic              cmd_snap_wr,
    output logic              load_busy,
    output logic              snap_busy,
    input  logic [CNT_W-1:0]  live_count,
    output logic [CNT_W-1:0]  load_value,
    output logic              load_strobe
);
    chan_t            req_bus, req_cnt;
    chan_t            ack_cnt, ack_bus;
    logic [CNT_W-1:0] hold_reg;
    logic [CNT_W-1:0] snap_reg;

    slb_bus_ctl #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_bus (
        .clk         (bus_clk),
        .rst_n       (bus_rst_n),
        .wr_en       (bus_wr_en),
        .wr_sel      (bus_wr_sel),
        .wr_data     (bus_wr_data),
        .rd_sel      (bus_rd_sel),
        .rd_data     (bus_rd_data),
        .cmd_load_wr (cmd_load_wr),
        .cmd_snap_wr (cmd_snap_wr),
        .ack_s       (ack_bus),
        .snap_data   (snap_reg),
        .hold_reg    (hold_reg),
        .req         (req_bus),
        .load_busy   (load_busy),
        .snap_busy   (snap_busy)
    );

    slb_sync #(.WIDTH(CHAN_N), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (cnt_clk),
        .rst_n (cnt_rst_n),
        .d     (req_bus),
        .q     (req_cnt)
    );

    slb_cnt_side #(.CNT_W(CNT_W)) u_cnt (
        .clk         (cnt_clk),
        .rst_n       (cnt_rst_n),
        .req_s       (req_cnt),
        .hold_data   (hold_reg),
        .live_count  (live_count),
        .load_value  (load_value),
        .load_strobe (load_strobe),
        .snap        (snap_reg),
        .ack         (ack_cnt)
    );

    slb_sync #(.WIDTH(CHAN_N), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (bus_clk),
        .rst_n (bus_rst_n),
        .d     (ack_cnt),
        .q     (ack_bus)
    );
endmodule

// File: tb/snap_load_bridge_bench.sv
// Scoreboard bench: the driver pushes expected load values into a queue,
// a counter-domain monitor pops and compares them on each load strobe.
module snap_load_bridge_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_PERIOD = 34;
    localparam int WATCHDOG   = 150000;

    logic        bus_clk = 0, cnt_clk = 0, rst_n = 0;
    logic        bus_wr_en = 0, cmd_load_wr = 0, cmd_snap_wr = 0;
    logic [1:0]  bus_wr_sel = 0, bus_rd_sel = 0;
    logic [7:0]  bus_wr_data = 0, bus_rd_data;
    logic        load_busy, snap_busy, load_strobe;
    logic [31:0] load_value, model_cnt;

    int compared = 0, mismatched = 0, strobes = 0;
    logic [31:0] exp_q[$];

    always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
    always #(CNT_PERIOD/2) cnt_clk = ~cnt_clk;

    snap_load_bridge u_snap_load_bridge (
        .bus_clk(bus_clk), .bus_rst_n(rst_n), .cnt_clk(cnt_clk), .cnt_rst_n(rst_n),
        .bus_wr_en(bus_wr_en), .bus_wr_sel(bus_wr_sel), .bus_wr_data(bus_wr_data),
        .bus_rd_sel(bus_rd_sel), .bus_rd_data(bus_rd_data),
        .cmd_load_wr(cmd_load_wr), .cmd_snap_wr(cmd_snap_wr),
        .load_busy(load_busy), .snap_busy(snap_busy),
        .live_count(model_cnt), .load_value(load_value), .load_strobe(load_strobe)
    );

    // Counter model outside the block: counts every cycle, loads on strobe.
    always_ff @(posedge cnt_clk) begin
        if (!rst_n)           model_cnt <= '0;
        else if (load_strobe) model_cnt <= load_value;
        else                  model_cnt <= model_cnt + 32'd1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: every load strobe pops one expected value (R3).
    always @(negedge cnt_clk) begin
        if (rst_n && load_strobe) begin
            strobes++;
            if (exp_q.size() == 0) begin
                check(0, "R3 unexpected strobe", load_value, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(load_value == e, "R3 load value", load_value, e);
            end
        end
    end

    task automatic write_hold(input logic [31:0] v);
        for (int k = 0; k < 4; k++) begin
            bus_wr_en = 1; bus_wr_sel = 2'(k); bus_wr_data = v[k*8 +: 8];
            @(negedge bus_clk);
        end
        bus_wr_en = 0;
    endtask

    task automatic read_hold(output logic [31:0] v);
        for (int k = 0; k < 4; k++) begin
            bus_rd_sel = 2'(k);
            #1;
            v[k*8 +: 8] = bus_rd_data;
        end
    endtask

    task automatic issue(input bit ld, input bit sn);
        cmd_load_wr = ld; cmd_snap_wr = sn;
        @(negedge bus_clk);
        cmd_load_wr = 0; cmd_snap_wr = 0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while ((load_busy || snap_busy) && n < 400) begin
            @(negedge bus_clk);
            n++;
        end
        check(!load_busy && !snap_busy, req, {30'd0, load_busy, snap_busy}, 32'h0);
    endtask

    task automatic snap_check(input logic [31:0] lo, input string req);
        logic [31:0] hi, v;
        hi = model_cnt;
        read_hold(v);
        check(v >= lo && v <= hi, req, v, lo);
    endtask

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * WATCHDOG);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] v, lo;
        int s0;
        repeat (8) @(negedge cnt_clk);
        @(negedge bus_clk);
        // R1: reset state
        read_hold(v);
        check(v == 0, "R1 hold reg", v, 0);
        check(!load_busy && !snap_busy, "R1 command bits", {30'd0, load_busy, snap_busy}, 0);
        check(!load_strobe, "R1 strobe", {31'd0, load_strobe}, 0);
        rst_n = 1;
        repeat (4) @(negedge bus_clk);

        // R2: full write and single-byte write
        write_hold(32'h1234_5678);
        read_hold(v);
        check(v == 32'h1234_5678, "R2 readback", v, 32'h1234_5678);
        bus_wr_en = 1; bus_wr_sel = 2; bus_wr_data = 8'hAB;
        @(negedge bus_clk); bus_wr_en = 0;
        read_hold(v);
        check(v == 32'h12AB_5678, "R2 byte lane", v, 32'h12AB_5678);

        // R3/R4: load command
        write_hold(32'h0000_1000);
        exp_q.push_back(32'h0000_1000);
        issue(1, 0);
        check(load_busy, "R4 busy after write", {31'd0, load_busy}, 1);
        wait_idle("R4 load bit clears");

        // R5/R6: snapshot of a running count
        lo = model_cnt;
        issue(0, 1);
        check(snap_busy, "R6 busy after write", {31'd0, snap_busy}, 1);
        wait_idle("R6 snapshot bit clears");
        snap_check(lo, "R5 snapshot window");

        // R7: byte write during a pending load is ignored
        write_hold(32'h0000_2000);
        exp_q.push_back(32'h0000_2000);
        issue(1, 0);
        bus_wr_en = 1; bus_wr_sel = 0; bus_wr_data = 8'hFF;
        @(negedge bus_clk); bus_wr_en = 0;
        wait_idle("R7 load completes");
        read_hold(v);
        check(v == 32'h0000_2000, "R7 write ignored", v, 32'h0000_2000);

        // R9: repeated load command while pending gives one strobe
        write_hold(32'h0000_3000);
        exp_q.push_back(32'h0000_3000);
        s0 = strobes;
        issue(1, 0);
        issue(1, 0);
        issue(1, 0);
        wait_idle("R9 load completes");
        repeat (12) @(negedge cnt_clk);
        check(strobes - s0 == 1, "R9 single strobe", 32'(strobes - s0), 1);

        // R8: simultaneous load and snapshot, load first
        write_hold(32'hFFFF_0000);
        exp_q.push_back(32'hFFFF_0000);
        issue(1, 1);
        wait_idle("R8 both complete");
        snap_check(32'hFFFF_0000, "R8 snapshot after load");

        // R5: repeated snapshots at different moments
        for (int i = 0; i < 3; i++) begin
            repeat (7 + 13*i) @(negedge bus_clk);
            lo = model_cnt;
            issue(0, 1);
            wait_idle("R6 snapshot bit clears again");
            snap_check(lo, "R5 repeated snapshot");
        end

        repeat (12) @(negedge cnt_clk);
        check(exp_q.size() == 0, "R3 all loads seen", 32'(exp_q.size()), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule